// File: doc/BRIEF.md
# NOR flash reset sequencer

This block owns the active-low reset line of a parallel NOR flash and decides when the host may start driving the flash. It runs a power-up sequence whenever the synchronized supply-good input has been stable long enough. It also runs a warm reset when the host asks for one while the block is ready. While any reset is in progress, the block forces chip enable, output enable and write enable high, whatever the host drives. Once the reset timing has been met, it passes the host's three strobes straight through.

Every delay is a parameter counted in clock cycles. One parameter selects between two timing families:

- **State-independent mode.** Release comes after both of these have held: a minimum time since the reset line rose, and a long window since the reset line fell.
- **State-dependent mode.** The release rule depends on whether a program or erase was running when the warm reset began. In that case the block either waits a long window from the falling edge or watches the ready/busy pin. The pin watch has a timeout that falls back to that window and leaves a sticky flag.

Top module: `nor_rst_seq`

## Requirements
- R1: During power-up the reset output stays low until the synchronized supply-good has been high for T_VCS consecutive cycles, then for T_RP more cycles; the window end is the anchor for later timing.
- R2: If supply-good (two-flop synchronized) falls at any time, the reset output goes low and the ready output goes low within three cycles, and the whole power-up sequence restarts.
- R3: A warm-reset request sampled high while ready drives the reset output low at the next clock edge, for exactly T_RP cycles.
- R4: In state-independent mode (STATE_DEP=0), and after power-up in both modes, ready rises max(T_RP+T_RH, T_RPH) cycles after the anchor; the embedded-busy input has no effect.
- R5: In state-dependent mode with embedded-busy low at the accepted request, ready rises T_RP+T_RH cycles after the request edge, and the ready/busy pin has no effect.
- R6: In state-dependent mode with embedded-busy high and pin monitoring on (RB_MON=1), ready rises T_RB+1 cycles after the synchronized ready/busy pin is first seen high once the reset line has risen; the pin reads high for ready.
- R7: If the pin stays low for T_RBTO cycles after the reset line rose, the timeout output goes high and stays high until block reset. Ready then rises max(T_RP+T_RBTO+1, T_READY) cycles after the request edge.
- R8: While ready is low, the chip-enable, output-enable and write-enable outputs are all high; while ready is high, they follow the host inputs.
- R9: A warm-reset request while ready is low is ignored, and the embedded-busy input is sampled only on the accepted request.
- R10: Ready is low whenever the reset output is low, and ready only rises after the reset output has been high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| pwr_good_i | input | 1 | Supply-good, asynchronous |
| wrst_req_i | input | 1 | Single-cycle warm-reset request |
| embed_busy_i | input | 1 | Program or erase in progress, sampled with the request |
| flash_rb_i | input | 1 | Flash ready/busy pin, high = ready, asynchronous |
| host_ce_n_i | input | 1 | Host chip enable |
| host_oe_n_i | input | 1 | Host output enable |
| host_we_n_i | input | 1 | Host write enable |
| flash_rst_n_o | output | 1 | Reset line to the flash, active low |
| flash_ce_n_o | output | 1 | Gated chip enable |
| flash_oe_n_o | output | 1 | Gated output enable |
| flash_we_n_o | output | 1 | Gated write enable |
| access_ok_o | output | 1 | High when flash access may begin |
| rb_timeout_o | output | 1 | Sticky ready/busy timeout flag |

## Verification
The bench measures the exact edge at which ready returns in each release rule, so a design that takes the sum where it should take the later of two windows is caught. The same holds for one that counts the long window from the reset rise instead of the fall. It drives a second request during the hold phase, where a design that re-arms would stretch the pulse and delay release. A ready/busy pin that never rises must end in the fallback release with a flag that survives a later reset; a design without the timeout would hang. A supply dip while ready must drop access and replay the full power-up count.

// File: rtl/nor_rst_seq.sv
module nor_rst_seq #(
  parameter int CW        = 16,
  parameter int T_VCS     = 30000,
  parameter int T_RP      = 20,
  parameter int T_RH      = 5,
  parameter int T_RPH     = 3500,
  parameter int T_READY   = 3500,
  parameter int T_RB      = 0,
  parameter int T_RBTO    = 10000,
  parameter bit STATE_DEP = 1'b0,
  parameter bit RB_MON    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic wrst_req_i,
  input  logic embed_busy_i,
  input  logic flash_rb_i,
  input  logic host_ce_n_i,
  input  logic host_oe_n_i,
  input  logic host_we_n_i,
  output logic flash_rst_n_o,
  output logic flash_ce_n_o,
  output logic flash_oe_n_o,
  output logic flash_we_n_o,
  output logic access_ok_o,
  output logic rb_timeout_o
);

  localparam int W = CW + 1;
  localparam logic [CW:0] K_VCS   = W'(T_VCS);
  localparam logic [CW:0] K_RP    = W'(T_RP);
  localparam logic [CW:0] K_RH    = W'(T_RH);
  localparam logic [CW:0] K_RPH   = W'(T_RPH);
  localparam logic [CW:0] K_READY = W'(T_READY);
  localparam logic [CW:0] K_RB    = W'(T_RB);
  localparam logic [CW:0] K_RBTO  = W'(T_RBTO);

  typedef enum logic [2:0] {
    ST_POR, ST_LOW, ST_HOLD, ST_RB, ST_RBD, ST_FBK, ST_RDY
  } st_t;

  st_t         state;
  logic [CW-1:0] t_lo, t_hi;
  logic        pg_s1, pg_s2, rb_s1, rb_s2;
  logic        emb_q, por_q, to_q;
  logic [CW:0] lo_n, hi_n, hi_c;
  logic        rel_hold;

  assign lo_n = {1'b0, t_lo} + 1'b1;
  assign hi_n = {1'b0, t_hi} + 1'b1;
  assign hi_c = {1'b0, t_hi};

  assign rel_hold = (hi_n >= K_RH) &&
                    ((STATE_DEP && !por_q) ? (!emb_q || lo_n >= K_READY)
                                           : (lo_n >= K_RPH));

  assign access_ok_o   = (state == ST_RDY);
  assign flash_rst_n_o = !(state == ST_POR || state == ST_LOW);
  assign flash_ce_n_o  = access_ok_o ? host_ce_n_i : 1'b1;
  assign flash_oe_n_o  = access_ok_o ? host_oe_n_i : 1'b1;
  assign flash_we_n_o  = access_ok_o ? host_we_n_i : 1'b1;
  assign rb_timeout_o  = to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_POR;
      t_lo  <= '0;
      t_hi  <= '0;
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
      rb_s1 <= 1'b0;
      rb_s2 <= 1'b0;
      emb_q <= 1'b0;
      por_q <= 1'b1;
      to_q  <= 1'b0;
    end else begin
      pg_s1 <= pwr_good_i;
      pg_s2 <= pg_s1;
      rb_s1 <= flash_rb_i;
      rb_s2 <= rb_s1;
      t_lo  <= (&t_lo) ? t_lo : t_lo + 1'b1;
      t_hi  <= (&t_hi) ? t_hi : t_hi + 1'b1;
      if (!pg_s2 && state != ST_POR) begin
        state <= ST_POR;
        t_lo  <= '0;
        por_q <= 1'b1;
        emb_q <= 1'b0;
      end else begin
        case (state)
          ST_POR: begin
            if (!pg_s2) t_lo <= '0;
            else if (lo_n >= K_VCS) begin
              state <= ST_LOW;
              t_lo  <= '0;
            end
          end
          ST_LOW: begin
            if (lo_n >= K_RP) begin
              t_hi  <= '0;
              state <= (STATE_DEP && RB_MON && emb_q) ? ST_RB : ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (rel_hold) begin
              state <= ST_RDY;
              por_q <= 1'b0;
            end
          end
          ST_RB: begin
            if (rb_s2) begin
              state <= ST_RBD;
              t_hi  <= '0;
            end else if (hi_n >= K_RBTO) begin
              to_q  <= 1'b1;
              state <= ST_FBK;
            end
          end
          ST_RBD:  if (hi_c >= K_RB) state <= ST_RDY;
          ST_FBK:  if (lo_n >= K_READY) state <= ST_RDY;
          ST_RDY: begin
            if (wrst_req_i) begin
              state <= ST_LOW;
              t_lo  <= '0;
              emb_q <= embed_busy_i;
            end
          end
          default: state <= ST_POR;
        endcase
      end
    end
  end

  p_rise_after_good_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_rst_n_o) |-> $past(pg_s2));

  p_drop_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s2 |=> (!access_ok_o && !flash_rst_n_o));

  p_req_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ok_o && wrst_req_i && pg_s2) |=> !flash_rst_n_o);

  p_to_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_timeout_o |=> rb_timeout_o);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !access_ok_o |-> (flash_ce_n_o && flash_oe_n_o && flash_we_n_o));

  p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_ok_o && flash_rst_n_o && wrst_req_i && pg_s2) |=> flash_rst_n_o);

  p_low_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_rst_n_o |-> !access_ok_o);

  p_release_after_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ok_o) |-> $past(flash_rst_n_o));

endmodule

// File: tb/nor_rst_seq_test.sv
module nor_rst_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pg = 2'b11, req = 2'b00, emb = 2'b00;
  logic rb1 = 1'b1;
  logic hce = 1'b0, hoe = 1'b0, hwe = 1'b0;
  logic [1:0] frst, fce, foe, fwe, acc, tof;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  nor_rst_seq #(.CW(12), .T_VCS(20), .T_RP(4), .T_RH(3), .T_RPH(12),
    .T_READY(30), .T_RB(2), .T_RBTO(15), .STATE_DEP(1'b0), .RB_MON(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg[0]), .wrst_req_i(req[0]),
    .embed_busy_i(emb[0]), .flash_rb_i(1'b1), .host_ce_n_i(hce),
    .host_oe_n_i(hoe), .host_we_n_i(hwe), .flash_rst_n_o(frst[0]),
    .flash_ce_n_o(fce[0]), .flash_oe_n_o(foe[0]), .flash_we_n_o(fwe[0]),
    .access_ok_o(acc[0]), .rb_timeout_o(tof[0]));

  nor_rst_seq #(.CW(12), .T_VCS(10), .T_RP(5), .T_RH(2), .T_RPH(9),
    .T_READY(30), .T_RB(2), .T_RBTO(15), .STATE_DEP(1'b1), .RB_MON(1'b1)) uut_dep (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pg[1]), .wrst_req_i(req[1]),
    .embed_busy_i(emb[1]), .flash_rb_i(rb1), .host_ce_n_i(hce),
    .host_oe_n_i(hoe), .host_we_n_i(hwe), .flash_rst_n_o(frst[1]),
    .flash_ce_n_o(fce[1]), .flash_oe_n_o(foe[1]), .flash_we_n_o(fwe[1]),
    .access_ok_o(acc[1]), .rb_timeout_o(tof[1]));

  // sel, emb, rb level, expected edges to ready, expected low cycles
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{0, 0, 1, 13, 4},
    '{0, 1, 1, 13, 4},
    '{1, 0, 1,  8, 5},
    '{1, 1, 1, 10, 5},
    '{1, 0, 0,  8, 5}
  };

  task automatic check(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic warm(input int sel, input bit e, input int rb_at, input int req2_at,
                      output int n, output int lo, output int gate_busy);
    @(negedge clk);
    req[sel] = 1'b1;
    emb[sel] = e;
    n = 0; lo = 0; gate_busy = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req = 2'b00;
      if (n == rb_at) rb1 = 1'b1;
      if (n == req2_at) req[sel] = 1'b1;
      if (!frst[sel]) lo++;
      if (n == 2) gate_busy = {fce[sel], foe[sel], fwe[sel]};
    end while (!acc[sel] && n < 500);
    req = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, lo, g, n0, n1, lo0, lo1;
    repeat (3) @(negedge clk);
    check("R10 reset state rst", frst, 0);
    check("R8 reset state ready", acc, 0);
    rst_n = 1'b1;
    n = 0; n0 = 0; n1 = 0; lo0 = 0; lo1 = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!frst[0]) lo0++;
      if (!frst[1]) lo1++;
      if (acc[0] && n0 == 0) n0 = n;
      if (acc[1] && n1 == 0) n1 = n;
    end while ((n0 == 0 || n1 == 0) && n < 500);
    check("R1 power-up low time indep", lo0, 25);
    check("R1 power-up low time dep", lo1, 16);
    check("R4 power-up release indep", n0, 34);
    check("R4 power-up release dep", n1, 21);

    for (int i = 0; i < NV; i++) begin
      rb1 = VEC[i][2][0];
      repeat (3) @(negedge clk);
      warm(VEC[i][0], VEC[i][1][0], -1, -1, n, lo, g);
      check("R3 warm pulse width", lo, VEC[i][4]);
      if (i < 2) check("R4 indep release", n, VEC[i][3]);
      else if (i == 3) check("R6 rb already high release", n, VEC[i][3]);
      else check("R5 dep no-op release", n, VEC[i][3]);
    end

    // R8 strobes gated during reset, passed once ready
    warm(0, 1'b0, -1, -1, n, lo, g);
    check("R8 strobes high while busy", g, 7);
    check("R8 strobes follow host", {fce[0], foe[0], fwe[0]}, 0);
    hce = 1'b1;
    #1;
    check("R8 ce follows host high", fce[0], 1);
    hce = 1'b0;

    // R9 second request during hold is ignored
    warm(0, 1'b0, -1, 8, n, lo, g);
    check("R9 request while busy ignored", n, 13);
    check("R9 pulse not stretched", lo, 4);
    lo = 0;
    repeat (5) begin
      @(negedge clk);
      if (!frst[0] || !acc[0]) lo++;
    end
    check("R9 no second reset", lo, 0);

    // R6 late ready/busy rise
    rb1 = 1'b0;
    repeat (3) @(negedge clk);
    warm(1, 1'b1, 10, -1, n, lo, g);
    check("R6 release after rb high", n, 16);
    check("R7 no timeout yet", tof[1], 0);

    // R2 supply dip restarts power-up
    @(negedge clk);
    pg[0] = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 reset low after dip", frst[0], 0);
    check("R2 ready low after dip", acc[0], 0);
    pg[0] = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!acc[0] && n < 500);
    check("R2 full power-up replayed", n, 34);

    // R7 timeout fallback and sticky flag
    rb1 = 1'b0;
    repeat (3) @(negedge clk);
    warm(1, 1'b1, -1, -1, n, lo, g);
    check("R7 fallback release", n, 31);
    check("R7 timeout flag set", tof[1], 1);
    rb1 = 1'b1;
    repeat (3) @(negedge clk);
    warm(1, 1'b0, -1, -1, n, lo, g);
    check("R7 flag sticky", tof[1], 1);
    check("R5 release after timeout", n, 8);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule